// File: doc/BRIEF.md
# Register-Controlled Delay Tap Selector

This block is the digital control loop of a register-controlled delay-locked loop. A phase comparator outside the block compares the reference clock with the fed-back delayed clock. It issues one decision per valid strobe: add delay, trim delay, or hold because the error is within one unit delay. The block keeps a one-hot selection register. Its single active bit chooses the stage at which the reference clock enters a chain of identical delay stages. The reference feeds every stage in common, so any stage can serve as the entry point.

The inserted delay is the number of stages the reference passes through from the chosen entry point to the chain output. One step of the pointer is therefore one unit delay, and the whole chain sets the deskew range. The block contains a cycle-level behavioural model of the chain, in which each stage is one register. It also raises a lock flag after a programmable run of consecutive in-band decisions. It flags the case where the pointer sits at an end of the chain and is still being pushed past it.

Top module: `dll_tap_select`

## Requirements
- R1: While reset is asserted and directly after it, `tap_sel` is 1 (bit 0 set, minimum delay), `locked` and `range_err` are 0, and `dly_out` is 0.
- R2: `tap_sel` has exactly one bit set in every cycle.
- R3: A strobe with `dec_code` = 2'b01 (add) moves the active bit from position p to p+1. A strobe with `dec_code` = 2'b10 (trim) moves it from p to p-1. There is at most one move per strobe, and the move is visible in the cycle after the sampling edge.
- R4: When `dec_vld` is 0, `tap_sel`, `locked` and `range_err` keep their values, whatever `dec_code` carries.
- R5: A strobe with `dec_code` = 2'b00 or 2'b11 (in band) leaves `tap_sel` unchanged.
- R6: An add strobe with bit STAGES-1 active, or a trim strobe with bit 0 active, leaves `tap_sel` unchanged and sets `range_err`. The pointer never wraps.
- R7: Every strobe that is not a blocked move at an end clears `range_err`.
- R8: `locked` rises in the cycle after the LOCK_RUN-th consecutive in-band strobe. Cycles without a strobe do not break the run. It stays high through further in-band strobes.
- R9: Any add or trim strobe, including one blocked at an end, clears `locked` in the next cycle and restarts the in-band run.
- R10: With bit p of `tap_sel` active and held, `dly_out` equals `ref_in` as sampled p+1 clock edges earlier, once the chain has flushed. A one-step pointer move changes the delay by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | Decision strobe from the phase comparator |
| dec_code | input | 2 | 00/11 in band, 01 add delay, 10 trim delay |
| ref_in | input | 1 | Sampled reference clock into the delay chain |
| tap_sel | output | STAGES | One-hot entry-point selection |
| dly_out | output | 1 | Output of the modelled delay chain |
| locked | output | 1 | Lock indicator |
| range_err | output | 1 | Pointer pinned at an end while commanded further |

## Verification
A wrong pointer shows at `tap_sel` in the very next cycle. It also appears at `dly_out` as a delay off by whole cycles once the chain flushes, which takes at most STAGES cycles. A miscounted in-band run moves the `locked` edge earlier or later by whole strobes. A faulty end check shows one cycle after the offending strobe, either as a wrapped pointer or as a missing `range_err`. The bench walks the pointer to both ends and builds locks at two positions. It measures the chain delay at a high tap and at the lowest tap.

// File: rtl/dll_sel_pkg.sv
package dll_sel_pkg;
   typedef enum logic [1:0] {
      DEC_HOLD     = 2'b00,
      DEC_ADD      = 2'b01,
      DEC_TRIM     = 2'b10,
      DEC_HOLD_ALT = 2'b11
   } dec_e;

   function automatic logic dec_in_band(input dec_e d);
      return (d == DEC_HOLD) || (d == DEC_HOLD_ALT);
   endfunction
endpackage

// File: rtl/dll_tap_ptr.sv
module dll_tap_ptr #(
   parameter int STAGES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_vld,
   input  logic              step_up,
   input  logic              step_dn,
   output logic [STAGES-1:0] sel_oh,
   output logic              pinned
);
   localparam logic [STAGES-1:0] SEL_MIN = STAGES'(1);

   logic [STAGES-1:0] sel_q;
   logic              pin_q;
   logic              at_top;
   logic              at_bot;

   assign at_top = sel_q[STAGES-1];
   assign at_bot = sel_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_MIN;
         pin_q <= 1'b0;
      end else if (step_vld) begin
         if (step_up) begin
            if (at_top) pin_q <= 1'b1;
            else begin
               sel_q <= sel_q << 1;
               pin_q <= 1'b0;
            end
         end else if (step_dn) begin
            if (at_bot) pin_q <= 1'b1;
            else begin
               sel_q <= sel_q >> 1;
               pin_q <= 1'b0;
            end
         end else begin
            pin_q <= 1'b0;
         end
      end
   end

   assign sel_oh = sel_q;
   assign pinned = pin_q;

   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_q) == 1);
   // R4
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_vld |=> $stable(sel_q) && $stable(pin_q));
   // R3
   sel_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_vld |=> (sel_q == $past(sel_q)) || (sel_q == ($past(sel_q) << 1))
                   || (sel_q == ($past(sel_q) >> 1)));
   // R6
   top_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vld && step_up && at_top) |=> sel_q[STAGES-1] && pin_q);
   // R6
   bot_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vld && step_dn && !step_up && at_bot) |=> sel_q[0] && pin_q);
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det #(
   parameter int LOCK_RUN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dec_vld,
   input  logic in_band,
   output logic locked
);
   logic lock_q;

   generate
      if (LOCK_RUN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lock_q <= 1'b0;
            else if (dec_vld) lock_q <= in_band;
         end
      end else begin : g_count
         localparam int CW = $clog2(LOCK_RUN + 1);
         localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               lock_q <= 1'b0;
            end else if (dec_vld) begin
               if (in_band) begin
                  if (!lock_q) run_q <= run_q + 1'b1;
                  if (run_q == RUN_LAST) lock_q <= 1'b1;
               end else begin
                  run_q  <= '0;
                  lock_q <= 1'b0;
               end
            end
         end
      end
   endgenerate

   assign locked = lock_q;

   // R9
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && !in_band) |=> !lock_q);
   // R4
   lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |=> $stable(lock_q));
   // R8
   lock_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(dec_vld) && $past(in_band));
endmodule

// File: rtl/dll_delay_model.sv
module dll_delay_model #(
   parameter int STAGES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic [STAGES-1:0] sel_oh,
   output logic              dly_out
);
   logic [STAGES-1:0] stg_q;

   generate
      for (genvar j = 0; j < STAGES; j++) begin : g_stage
         logic upstream;
         if (j == 0) begin : g_head
            assign upstream = 1'b0;
         end else begin : g_link
            assign upstream = stg_q[j-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[j] <= 1'b0;
            else        stg_q[j] <= sel_oh[STAGES-1-j] ? ref_in : upstream;
         end
      end
   endgenerate

   assign dly_out = stg_q[STAGES-1];

   // R10
   min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_oh[0] |=> dly_out == $past(ref_in));
endmodule

// File: rtl/dll_tap_select.sv
module dll_tap_select
   import dll_sel_pkg::*;
#(
   parameter int STAGES   = 16,
   parameter int LOCK_RUN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_vld,
   input  logic [1:0]        dec_code,
   input  logic              ref_in,
   output logic [STAGES-1:0] tap_sel,
   output logic              dly_out,
   output logic              locked,
   output logic              range_err
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dll_tap_select: STAGES must be at least 2");
      end
      if (LOCK_RUN < 1) begin : g_bad_run
         $error("dll_tap_select: LOCK_RUN must be at least 1");
      end
   endgenerate

   dec_e dec;
   logic in_band;
   logic want_up;
   logic want_dn;

   assign dec     = dec_e'(dec_code);
   assign in_band = dec_in_band(dec);
   assign want_up = (dec == DEC_ADD);
   assign want_dn = (dec == DEC_TRIM);

   dll_tap_ptr #(.STAGES(STAGES)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_vld (dec_vld),
      .step_up  (want_up),
      .step_dn  (want_dn),
      .sel_oh   (tap_sel),
      .pinned   (range_err)
   );

   dll_lock_det #(.LOCK_RUN(LOCK_RUN)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_vld (dec_vld),
      .in_band (in_band),
      .locked  (locked)
   );

   dll_delay_model #(.STAGES(STAGES)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_in  (ref_in),
      .sel_oh  (tap_sel),
      .dly_out (dly_out)
   );

   // R5
   hold_keeps_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && in_band) |=> $stable(tap_sel));
   // R7
   range_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && in_band) |=> !range_err);
endmodule

// File: tb/tb_dll_tap_select.sv
module tb_dll_tap_select;
   localparam int N   = 8;
   localparam int RUN = 3;
   localparam int NV  = 23;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dec_vld = 1'b0;
   logic [1:0]   dec_code = 2'b00;
   logic         ref_in = 1'b0;
   logic [N-1:0] tap_sel;
   logic         dly_out, locked, range_err;

   int vectors = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dll_tap_select #(.STAGES(N), .LOCK_RUN(RUN)) dut (
      .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_code(dec_code),
      .ref_in(ref_in), .tap_sel(tap_sel), .dly_out(dly_out),
      .locked(locked), .range_err(range_err)
   );

   // {vld, code, expected index, expected lock, expected range flag}
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 2'b10, 4'd0, 1'b0, 1'b1},
      {1'b1, 2'b00, 4'd0, 1'b0, 1'b0},
      {1'b0, 2'b01, 4'd0, 1'b0, 1'b0},
      {1'b1, 2'b00, 4'd0, 1'b0, 1'b0},
      {1'b1, 2'b11, 4'd0, 1'b1, 1'b0},
      {1'b1, 2'b01, 4'd1, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd2, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd3, 1'b0, 1'b0},
      {1'b1, 2'b10, 4'd2, 1'b0, 1'b0},
      {1'b0, 2'b10, 4'd2, 1'b0, 1'b0},
      {1'b1, 2'b00, 4'd2, 1'b0, 1'b0},
      {1'b1, 2'b00, 4'd2, 1'b0, 1'b0},
      {1'b1, 2'b00, 4'd2, 1'b1, 1'b0},
      {1'b1, 2'b00, 4'd2, 1'b1, 1'b0},
      {1'b0, 2'b01, 4'd2, 1'b1, 1'b0},
      {1'b1, 2'b01, 4'd3, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd4, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd5, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd6, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd7, 1'b0, 1'b0},
      {1'b1, 2'b01, 4'd7, 1'b0, 1'b1},
      {1'b1, 2'b01, 4'd7, 1'b0, 1'b1},
      {1'b1, 2'b10, 4'd6, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic strobe(input logic v, input logic [1:0] c);
      @(negedge clk);
      dec_vld  = v;
      dec_code = c;
      @(negedge clk);
      dec_vld  = 1'b0;
   endtask

   logic [15:0] lfsr = 16'hACE1;
   logic        hist [N+1];

   task automatic delay_check(input int p, input string req);
      for (int i = 0; i <= N; i++) hist[i] = 1'b0;
      for (int cyc = 0; cyc < N + 14; cyc++) begin
         @(negedge clk);
         if (cyc >= N + 2) chk(req, 32'(dly_out), 32'(hist[p]));
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         for (int i = N; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = lfsr[0];
         ref_in  = lfsr[0];
      end
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, sampled while reset is held
      chk("R1 tap", 32'(tap_sel), 32'd1);
      chk("R1 lock", 32'(locked), 32'd0);
      chk("R1 range", 32'(range_err), 32'd0);
      chk("R1 dly", 32'(dly_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tap after release", 32'(tap_sel), 32'd1);

      for (int k = 0; k < NV; k++) begin
         dec_vld  = VEC[k][8];
         dec_code = VEC[k][7:6];
         @(negedge clk);
         dec_vld = 1'b0;
         // R3 R4 R5 R6 pointer
         chk("R3/R4/R5/R6 tap", 32'(tap_sel), 32'(1) << VEC[k][5:2]);
         // R8 R9 lock
         chk("R8/R9 lock", 32'(locked), 32'(VEC[k][1]));
         // R6 R7 range flag
         chk("R6/R7 range", 32'(range_err), 32'(VEC[k][0]));
         // R2
         chk("R2 onehot", 32'($countones(tap_sel)), 32'd1);
      end

      // R10 delay at index 6
      delay_check(6, "R10 delay p6");
      // R10 one step lower gives one cycle less
      strobe(1'b1, 2'b10);
      chk("R3 step to 5", 32'(tap_sel), 32'd32);
      delay_check(5, "R10 delay p5");
      for (int s = 0; s < 5; s++) strobe(1'b1, 2'b10);
      chk("R6 reached bottom", 32'(tap_sel), 32'd1);
      delay_check(0, "R10 delay p0");

      // R9 blocked move at bottom still drops lock
      for (int s = 0; s < RUN; s++) strobe(1'b1, 2'b00);
      chk("R8 lock at bottom", 32'(locked), 32'd1);
      strobe(1'b1, 2'b10);
      chk("R9 blocked trim drops lock", 32'(locked), 32'd0);
      chk("R6 blocked trim flags", 32'(range_err), 32'd1);

      // R1 reset clears a moved, locked state
      strobe(1'b1, 2'b01);
      strobe(1'b1, 2'b01);
      for (int s = 0; s < RUN; s++) strobe(1'b1, 2'b11);
      chk("R8 lock before reset", 32'(locked), 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 tap on reset", 32'(tap_sel), 32'd1);
      chk("R1 lock on reset", 32'(locked), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      summary();
   end
endmodule